// File: doc/BRIEF.md
# Vector Configuration and Length Controller

This block keeps the control state of a vector unit: which element widths are in use and how many registers each one has, the active vector length, and two pending modifier flags (predicate and save-carry). It takes one decoded control operation per cycle and answers one cycle later. The answer is a scalar result, an illegal-configuration exception, a request to clear all vector registers to zero, or an illegal-operation flag.

The configuration is built up one width at a time. Nothing is checked while it is being built. The register total is checked only when the first length-setting operation arrives. If it is valid, the configuration is locked until the unit is unconfigured or reset. The longest allowed vector length is computed from the register mix and a parameterised storage size per lane group.

Top module: `vcfg_ctrl`

## Requirements
- R1: After reset, `cfg_state` is 0 (powered off), `vl` and `max_vl` are 0, both modifier flags are clear, and no result, exception or illegal flag is raised.
- R2: A config step (`op_code`=1) takes `rd_idx` as log2 of the element width in bits (valid values 3 to 6) and `rs1_idx` as the register count, where 0 means 32. A later step at the same width replaces the earlier count. The step moves the unit to building state (`cfg_state`=2), from the off state as well.
- R3: A length operation (`op_code`=2, `rd_idx`!=0) in building state is an invalid configuration if the register total exceeds 32, if the total is zero, or if any step used an unsupported width. One cycle later it raises `exc_cfg` with no `res_valid`, returns the unit to `cfg_state`=1, and discards the partial configuration.
- R4: A valid completion moves the unit to `cfg_state`=3 and pulses `zero_regs` for one cycle. It also sets `max_vl` to STORE_BITS divided by the sum over widths of count times width in bits, rounded down.
- R5: A length operation with `rs1_idx`!=0 sets `vl` to the smaller of `rs1_val` and `max_vl`. The new `vl` is returned on `res_data` with `res_valid` one cycle later.
- R6: A length operation with `rs1_idx`=0 and `rd_idx`!=0 leaves `vl` unchanged and returns it.
- R7: Every length-class operation clears both pending modifiers, including the get-length form. With `rd_idx`=0 and `rs1_idx`=0 it does nothing else and gives no result.
- R8: With `rd_idx`=0, code `rs1_idx`=1 unconfigures the unit (`cfg_state`=0, `vl`=0). Code 2 resets it to `cfg_state`=1 from any state, including off.
- R9: A config step while configured raises `illegal_op` and leaves `vl` and `max_vl` unchanged.
- R10: `op_code`=3 sets the predicate flag and `op_code`=4 sets the save-carry flag. A vector operation (`vec_valid`) clears the predicate flag only if `vec_uses_pred` is set, and clears the save-carry flag only if `vec_is_add` is set. Other vector operations leave both flags as they are.
- R11: A vector operation, a modifier-set operation, or a length operation with `rd_idx`!=0 raises `illegal_op` when issued while the unit is off or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Control operation present |
| op_code | input | 3 | 1 step, 2 length class, 3 set predicate, 4 set carry |
| rd_idx | input | 5 | Destination field |
| rs1_idx | input | 5 | Source field |
| rs1_val | input | XLEN | Requested length value |
| vec_valid | input | 1 | Non-control vector operation issued |
| vec_uses_pred | input | 1 | That operation consumes the predicate flag |
| vec_is_add | input | 1 | That operation is an addition consuming save-carry |
| res_valid | output | 1 | Scalar result valid |
| res_data | output | XLEN | Scalar result |
| exc_cfg | output | 1 | Illegal-configuration exception |
| zero_regs | output | 1 | Clear all vector registers |
| illegal_op | output | 1 | Operation not allowed in current state |
| cfg_state | output | 2 | 0 off, 1 idle, 2 building, 3 configured |
| vl | output | VLW | Current vector length |
| max_vl | output | VLW | Maximum length of current configuration |
| pred_pend | output | 1 | Predicate modifier pending |
| carry_pend | output | 1 | Save-carry modifier pending |

## Verification
The assertions assume that `op_valid` and `vec_valid` are never high in the same cycle. If they are, the control operation wins and the vector operation is dropped. The bench drives one kind of stimulus per cycle and returns every input to idle between operations, so this assumption always holds. The assertions also take `rs1_val` as unsigned. The bench requests lengths both above and below the computed maximum so that both sides of the minimum are checked.

// File: rtl/vcfg_ctrl.sv
module vcfg_ctrl #(
  parameter int XLEN       = 32,
  parameter int STORE_BITS = 8192,
  parameter int NREG       = 32,
  parameter int MINW_LOG   = 3,
  parameter int NWID       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [4:0]      rd_idx,
  input  logic [4:0]      rs1_idx,
  input  logic [XLEN-1:0] rs1_val,
  input  logic            vec_valid,
  input  logic            vec_uses_pred,
  input  logic            vec_is_add,
  output logic            res_valid,
  output logic [XLEN-1:0] res_data,
  output logic            exc_cfg,
  output logic            zero_regs,
  output logic            illegal_op,
  output logic [1:0]      cfg_state,
  output logic [$clog2(STORE_BITS/(1<<MINW_LOG)+1)-1:0] vl,
  output logic [$clog2(STORE_BITS/(1<<MINW_LOG)+1)-1:0] max_vl,
  output logic            pred_pend,
  output logic            carry_pend
);
  localparam int VLW = $clog2(STORE_BITS/(1<<MINW_LOG)+1);
  localparam int CW  = $clog2(NREG+1);
  localparam int TW  = $clog2(NWID*NREG+1);
  localparam int BW  = $clog2(NWID*NREG*(1<<(MINW_LOG+NWID-1))+1) + 1;
  localparam int IW  = $clog2(NWID);

  localparam logic [2:0] OP_STEP = 3'd1, OP_LEN = 3'd2, OP_PRED = 3'd3, OP_CARRY = 3'd4;
  localparam logic [1:0] S_OFF = 2'd0, S_IDLE = 2'd1, S_BUILD = 2'd2, S_READY = 2'd3;

  logic [CW-1:0] cnt [NWID];
  logic          bad_w;
  logic [TW-1:0] reg_sum;
  logic [BW-1:0] bit_sum;
  logic [VLW-1:0] max_calc;
  logic          cfg_ok;

  always_comb begin
    reg_sum = '0;
    bit_sum = '0;
    for (int i = 0; i < NWID; i++) begin
      reg_sum = reg_sum + TW'(cnt[i]);
      bit_sum = bit_sum + (BW'(cnt[i]) << (MINW_LOG + i));
    end
  end

  assign cfg_ok   = !bad_w && reg_sum != '0 && reg_sum <= TW'(NREG);
  assign max_calc = (bit_sum == '0) ? '0 : VLW'(BW'(STORE_BITS) / bit_sum);

  wire           w_ok     = rd_idx >= 5'(MINW_LOG) && rd_idx < 5'(MINW_LOG + NWID);
  wire [IW-1:0]  w_sel    = IW'(rd_idx - 5'(MINW_LOG));
  wire [CW-1:0]  step_cnt = (rs1_idx == '0) ? CW'(NREG) : CW'(rs1_idx);

  function automatic logic [VLW-1:0] clamp(input logic [XLEN-1:0] r, input logic [VLW-1:0] m);
    return (r < XLEN'(m)) ? VLW'(r) : m;
  endfunction

  wire [VLW-1:0] len_ready = (rs1_idx == '0) ? vl : clamp(rs1_val, max_vl);
  wire [VLW-1:0] len_build = (rs1_idx == '0) ? vl : clamp(rs1_val, max_calc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_state <= S_OFF;
      vl <= '0; max_vl <= '0; bad_w <= 1'b0;
      pred_pend <= 1'b0; carry_pend <= 1'b0;
      res_valid <= 1'b0; res_data <= '0; exc_cfg <= 1'b0;
      zero_regs <= 1'b0; illegal_op <= 1'b0;
      for (int i = 0; i < NWID; i++) cnt[i] <= '0;
    end else begin
      res_valid <= 1'b0; exc_cfg <= 1'b0; zero_regs <= 1'b0; illegal_op <= 1'b0;
      if (op_valid) begin
        case (op_code)
          OP_STEP:
            if (cfg_state == S_READY) illegal_op <= 1'b1;
            else begin
              cfg_state <= S_BUILD;
              if (w_ok) cnt[w_sel] <= step_cnt;
              else bad_w <= 1'b1;
            end
          OP_LEN: begin
            pred_pend <= 1'b0; carry_pend <= 1'b0;
            if (rd_idx == '0) begin
              if (rs1_idx == 5'd1 || rs1_idx == 5'd2) begin
                cfg_state <= (rs1_idx == 5'd1) ? S_OFF : S_IDLE;
                vl <= '0; max_vl <= '0; bad_w <= 1'b0;
                for (int i = 0; i < NWID; i++) cnt[i] <= '0;
              end
            end else if (cfg_state == S_READY) begin
              vl <= len_ready;
              res_valid <= 1'b1; res_data <= XLEN'(len_ready);
            end else if (cfg_state == S_BUILD) begin
              if (cfg_ok) begin
                cfg_state <= S_READY; max_vl <= max_calc; zero_regs <= 1'b1;
                vl <= len_build;
                res_valid <= 1'b1; res_data <= XLEN'(len_build);
              end else begin
                exc_cfg <= 1'b1; cfg_state <= S_IDLE; bad_w <= 1'b0;
                for (int i = 0; i < NWID; i++) cnt[i] <= '0;
              end
            end else illegal_op <= 1'b1;
          end
          OP_PRED:  if (cfg_state == S_READY) pred_pend <= 1'b1;  else illegal_op <= 1'b1;
          OP_CARRY: if (cfg_state == S_READY) carry_pend <= 1'b1; else illegal_op <= 1'b1;
          default: ;
        endcase
      end else if (vec_valid) begin
        if (cfg_state != S_READY) illegal_op <= 1'b1;
        else begin
          if (vec_uses_pred) pred_pend <= 1'b0;
          if (vec_is_add) carry_pend <= 1'b0;
        end
      end
    end
  end

  a_r7_mods_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_LEN |=> !pred_pend && !carry_pend);
  a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_STEP && cfg_state == S_READY |=> illegal_op && cfg_state == S_READY && $stable(max_vl));
  a_r5_vl_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_state == S_READY |-> vl <= max_vl);
  a_r3_exc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    exc_cfg |-> cfg_state == S_IDLE && !res_valid);
  a_r4_zero_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    zero_regs |-> cfg_state == S_READY && $past(cfg_state) == S_BUILD);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal_op, exc_cfg, res_valid}));
  a_r8_off_no_len: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_state == S_OFF |-> vl == '0 && max_vl == '0);
endmodule

// File: tb/sim_vcfg_ctrl.sv
`timescale 1ns/1ps
module sim_vcfg_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0; logic [2:0] op_code = '0;
  logic [4:0] rd_idx = '0, rs1_idx = '0; logic [31:0] rs1_val = '0;
  logic vec_valid = 1'b0, vec_uses_pred = 1'b0, vec_is_add = 1'b0;
  logic res_valid, exc_cfg, zero_regs, illegal_op, pred_pend, carry_pend;
  logic [31:0] res_data; logic [1:0] cfg_state; logic [10:0] vl, max_vl;
  int checks = 0, errors = 0; bit done = 0;

  vcfg_ctrl u0 (.clk, .rst_n, .op_valid, .op_code, .rd_idx, .rs1_idx, .rs1_val,
    .vec_valid, .vec_uses_pred, .vec_is_add, .res_valid, .res_data, .exc_cfg,
    .zero_regs, .illegal_op, .cfg_state, .vl, .max_vl, .pred_pend, .carry_pend);

  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin errors++; $display("FAIL %s actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic op(logic [2:0] c, logic [4:0] d, logic [4:0] s, int v);
    op_valid = 1; op_code = c; rd_idx = d; rs1_idx = s; rs1_val = v;
    @(negedge clk); op_valid = 0; op_code = 0; rd_idx = 0; rs1_idx = 0; rs1_val = 0;
  endtask

  task automatic vop(bit p, bit a);
    vec_valid = 1; vec_uses_pred = p; vec_is_add = a;
    @(negedge clk); vec_valid = 0; vec_uses_pred = 0; vec_is_add = 0;
  endtask

  task automatic t_reset;
    chk("R1 state", cfg_state, 0); chk("R1 vl", vl, 0); chk("R1 max", max_vl, 0);
    chk("R1 mods", {pred_pend, carry_pend}, 0);
    chk("R1 pulses", {res_valid, exc_cfg, zero_regs, illegal_op}, 0);
  endtask

  task automatic t_off_illegal;
    vop(0, 0);        chk("R11 vec while off", illegal_op, 1);
    op(2, 1, 1, 5);   chk("R11 setvl while off", illegal_op, 1); chk("R11 no result", res_valid, 0);
    op(3, 0, 0, 0);   chk("R11 pred while off", illegal_op, 1); chk("R11 pred not set", pred_pend, 0);
    op(2, 0, 2, 0);   chk("R8 reset from off", cfg_state, 1);
  endtask

  task automatic t_single;
    op(1, 5, 8, 0);   chk("R2 building", cfg_state, 2);
    op(2, 1, 1, 100); chk("R4 ready", cfg_state, 3); chk("R4 zero_regs", zero_regs, 1);
    chk("R4 max", max_vl, 32); chk("R5 clamp", res_data, 32); chk("R5 valid", res_valid, 1);
    op(2, 1, 1, 20);  chk("R5 below max", res_data, 20); chk("R4 zero once", zero_regs, 0);
    op(2, 3, 0, 999); chk("R6 get", res_data, 20); chk("R6 vl kept", vl, 20);
  endtask

  task automatic t_locked;
    op(1, 3, 4, 0);   chk("R9 illegal", illegal_op, 1);
    op(2, 1, 0, 0);   chk("R9 vl kept", res_data, 20); chk("R9 max kept", max_vl, 32);
  endtask

  task automatic t_mods;
    op(3, 0, 0, 0); op(4, 0, 0, 0); chk("R10 both set", {pred_pend, carry_pend}, 3);
    vop(0, 0);      chk("R10 non-consumer keeps", {pred_pend, carry_pend}, 3);
    vop(0, 1);      chk("R10 add clears carry", {pred_pend, carry_pend}, 2);
    vop(1, 0);      chk("R10 pred consumed", {pred_pend, carry_pend}, 0);
    op(3, 0, 0, 0); op(4, 0, 0, 0);
    op(2, 0, 0, 0); chk("R7 clear mods", {pred_pend, carry_pend}, 0); chk("R7 no result", res_valid, 0);
    op(2, 1, 0, 0); chk("R7 vl unaffected", res_data, 20);
    op(3, 0, 0, 0); op(2, 1, 0, 0); chk("R7 get clears", pred_pend, 0);
  endtask

  task automatic t_unconfig;
    op(2, 0, 1, 0); chk("R8 off", cfg_state, 0); chk("R8 vl zero", vl, 0);
    op(1, 5, 1, 0); chk("R2 step powers on", cfg_state, 2);
    op(2, 0, 2, 0); chk("R8 reset idle", cfg_state, 1);
  endtask

  task automatic t_mix;
    op(1, 6, 4, 0); op(1, 4, 4, 0); op(1, 6, 2, 0);
    op(2, 1, 1, 1000); chk("R2 replace mix max", max_vl, 42); chk("R5 mix len", res_data, 42);
    op(2, 0, 2, 0);
    op(1, 3, 0, 0); op(2, 1, 1, 1000); chk("R2 zero means 32", max_vl, 32);
    op(2, 0, 2, 0);
    op(1, 5, 16, 0); op(1, 3, 16, 0); op(2, 1, 1, 5);
    chk("R4 exact 32 ok", cfg_state, 3); chk("R4 max 12", max_vl, 12); chk("R5 len 5", res_data, 5);
  endtask

  task automatic t_bad;
    op(2, 0, 2, 0);
    op(1, 5, 20, 0); op(1, 3, 20, 0); op(2, 1, 1, 8);
    chk("R3 total exc", exc_cfg, 1); chk("R3 no result", res_valid, 0); chk("R3 idle", cfg_state, 1);
    vop(0, 0); chk("R11 vec after exc", illegal_op, 1);
    op(1, 2, 1, 0); op(1, 5, 1, 0); op(2, 1, 1, 8); chk("R3 width exc", exc_cfg, 1);
    op(1, 5, 1, 0); op(2, 1, 1, 1000); chk("R3 discarded", max_vl, 256);
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset; t_off_illegal; t_single; t_locked; t_mods; t_unconfig; t_mix; t_bad;
    done = 1; finish_up;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++; $display("FAIL watchdog actual 0 expected 1");
      finish_up;
    end
  end
endmodule